// File: doc/BRIEF.md
# Bulk Endpoint Handshake Control Register

This block is the byte-wide control register of one bulk endpoint. Both a local register bus and the USB serial interface engine can reach it. It stores three bits. The first enables the endpoint. The second is a sticky halt (STALL) bit. The third is a transmit-arm bit that clears itself once a packet has been moved. From these bits and the current token, the block chooses the handshake the engine returns.

Software programs the register through a simple write port: a select, a write strobe and a data byte. The engine can also raise the halt bit, and it reports each finished packet with a pulse. Protocol events clear the halt: a bus reset, or a clear-feature endpoint-halt request aimed at this endpoint. Every token seen by the engine is presented on a valid/direction pair. The chosen handshake code appears one cycle later on a registered output.

Top module: `ep_hs_ctl`

## Requirements
- R1: After the synchronous reset, the read-back byte is 0x00 and the handshake code is 0 (no response).
- R2: The enable flag reads back in bit 0, the halt flag in bit 1 and the arm flag in bit 2. Bits 7 to 3 always read back as 0, whatever was written.
- R3: A selected write copies data bit 0 into the enable flag, whether that bit is 0 or 1.
- R4: The halt flag is set by a selected write with data bit 1 at 1, or by an engine stall-request pulse. Writing 0 to bit 1 has no effect.
- R5: The halt flag is cleared only by a bus reset pulse or a clear-halt pulse. If a clear and a set arrive in the same cycle, the clear wins.
- R6: A selected write with data bit 2 at 1 sets the arm flag, and writing 0 to that bit has no effect. A packet-complete pulse clears the flag and wins over a write in the same cycle. A packet-complete pulse while the flag is already 0 leaves the whole read-back byte unchanged.
- R7: Handshake codes are 0 for no response, 1 for ACK/data, 2 for NAK and 3 for STALL. The code is registered, so it reflects the token and the flags of the previous cycle. With no token, or with the enable flag at 0, the code is 0.
- R8: For an enabled endpoint with the halt flag set, every token, whether IN or OUT, gets code 3.
- R9: For an enabled endpoint that is not halted, the codes are: OUT while armed gives 2, OUT while not armed gives 1, IN while armed gives 1, and IN while not armed gives 2.
- R10: A write strobe without the select input changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read-back byte |
| bus_reset | input | 1 | USB bus reset pulse |
| clr_halt | input | 1 | Clear-feature endpoint-halt pulse for this endpoint |
| eng_stall_req | input | 1 | Engine request to halt the endpoint |
| pkt_done | input | 1 | Armed packet finished |
| tok_valid | input | 1 | A token is present this cycle |
| tok_in | input | 1 | Token direction: 1 = IN, 0 = OUT |
| hs_code | output | 2 | Registered handshake choice |

## Verification
The hardest situations to reach from the ports are the collisions within a single cycle. One is a halt set (by write or by engine request) landing in the same cycle as a bus reset or a clear-halt pulse. Another is an arm write arriving together with packet completion. The bench drives these pulse pairs on the same edge on purpose, and then reads back the flags. In addition, it sweeps all eight flag combinations against no token, IN and OUT, and checks all 256 write values for the read-back mask.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;
endpackage

// File: rtl/ep_ctl_bits.sv
module ep_ctl_bits #(
  parameter int DW        = 8,
  parameter int EN_BIT    = 0,
  parameter int STALL_BIT = 1,
  parameter int ARM_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic [DW-1:0] wdata,
  input  logic          bus_reset,
  input  logic          clr_halt,
  input  logic          eng_stall_req,
  input  logic          pkt_done,
  output logic          en_q,
  output logic          stall_q,
  output logic          arm_q
);
  logic en_n, stall_n, arm_n;
  logic stall_set, stall_clr, arm_set;

  always_comb begin
    stall_set = (wr_fire & wdata[STALL_BIT]) | eng_stall_req;
    stall_clr = bus_reset | clr_halt;
    arm_set   = wr_fire & wdata[ARM_BIT];
    en_n      = wr_fire ? wdata[EN_BIT] : en_q;
    // clearing events take precedence over any set in the same cycle
    if (stall_clr)      stall_n = 1'b0;
    else if (stall_set) stall_n = 1'b1;
    else                stall_n = stall_q;
    if (pkt_done)       arm_n = 1'b0;
    else if (arm_set)   arm_n = 1'b1;
    else                arm_n = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      stall_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      en_q    <= en_n;
      stall_q <= stall_n;
      arm_q   <= arm_n;
    end
  end
endmodule

// File: rtl/ep_hs_select.sv
module ep_hs_select
  import ep_hs_pkg::*;
(
  input  logic tok_valid,
  input  logic tok_in,
  input  logic en,
  input  logic stall,
  input  logic arm,
  output hs_e  hs
);
  always_comb begin
    if (!tok_valid || !en) hs = HS_NONE;
    else if (stall)        hs = HS_STALL;
    else if (tok_in)       hs = arm ? HS_ACK : HS_NAK;
    else                   hs = arm ? HS_NAK : HS_ACK;
  end
endmodule

// File: rtl/ep_hs_ctl.sv
module ep_hs_ctl
  import ep_hs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int EN_BIT    = 0,
  parameter int STALL_BIT = 1,
  parameter int ARM_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_reset,
  input  logic          clr_halt,
  input  logic          eng_stall_req,
  input  logic          pkt_done,
  input  logic          tok_valid,
  input  logic          tok_in,
  output logic [1:0]    hs_code
);
  localparam int HSW = $bits(hs_e);

  logic en_q, stall_q, arm_q;
  hs_e  hs_c;
  logic [HSW-1:0] hs_q;

  ep_ctl_bits #(
    .DW(DW), .EN_BIT(EN_BIT), .STALL_BIT(STALL_BIT), .ARM_BIT(ARM_BIT)
  ) u_bits (
    .clk           (clk),
    .rst           (rst),
    .wr_fire       (reg_sel & reg_wr),
    .wdata         (reg_wdata),
    .bus_reset     (bus_reset),
    .clr_halt      (clr_halt),
    .eng_stall_req (eng_stall_req),
    .pkt_done      (pkt_done),
    .en_q          (en_q),
    .stall_q       (stall_q),
    .arm_q         (arm_q)
  );

  ep_hs_select u_sel (
    .tok_valid (tok_valid),
    .tok_in    (tok_in),
    .en        (en_q),
    .stall     (stall_q),
    .arm       (arm_q),
    .hs        (hs_c)
  );

  always_ff @(posedge clk) begin
    if (rst) hs_q <= HSW'(HS_NONE);
    else     hs_q <= HSW'(hs_c);
  end
  assign hs_code = hs_q;

  for (genvar i = 0; i < DW; i++) begin : g_rd
    if (i == EN_BIT)         begin : g_en  assign reg_rdata[i] = en_q;    end
    else if (i == STALL_BIT) begin : g_st  assign reg_rdata[i] = stall_q; end
    else if (i == ARM_BIT)   begin : g_arm assign reg_rdata[i] = arm_q;   end
    else                     begin : g_z   assign reg_rdata[i] = 1'b0;    end
  end
endmodule

// File: rtl/ep_hs_ctl_chk.sv
module ep_hs_ctl_chk #(
  parameter int DW        = 8,
  parameter int EN_BIT    = 0,
  parameter int STALL_BIT = 1,
  parameter int ARM_BIT   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          bus_reset,
  input logic          clr_halt,
  input logic          eng_stall_req,
  input logic          pkt_done,
  input logic          tok_valid,
  input logic          tok_in,
  input logic [1:0]    hs_code
);
  localparam logic [DW-1:0] USED =
    (DW'(1) << EN_BIT) | (DW'(1) << STALL_BIT) | (DW'(1) << ARM_BIT);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~USED) == '0);

  a_r4_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[STALL_BIT] && !bus_reset && !clr_halt |=> reg_rdata[STALL_BIT]);

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (bus_reset || clr_halt) |=> !reg_rdata[STALL_BIT]);

  a_r6_done_clears_arm: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !reg_rdata[ARM_BIT]);

  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    (!tok_valid || !reg_rdata[EN_BIT]) |=> hs_code == 2'd0);

  a_r8_halt_answer: assert property (@(posedge clk) disable iff (rst)
    tok_valid && reg_rdata[EN_BIT] && reg_rdata[STALL_BIT] |=> hs_code == 2'd3);

  a_r10_unselected_quiet: assert property (@(posedge clk) disable iff (rst)
    !reg_sel && !bus_reset && !clr_halt && !eng_stall_req && !pkt_done
    |=> $stable(reg_rdata));
endmodule

bind ep_hs_ctl ep_hs_ctl_chk #(
  .DW(DW), .EN_BIT(EN_BIT), .STALL_BIT(STALL_BIT), .ARM_BIT(ARM_BIT)
) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_reset(bus_reset),
  .clr_halt(clr_halt), .eng_stall_req(eng_stall_req), .pkt_done(pkt_done),
  .tok_valid(tok_valid), .tok_in(tok_in), .hs_code(hs_code)
);

// File: tb/sim_ep_hs_ctl.sv
`timescale 1ns/1ps
module sim_ep_hs_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       bus_reset = 1'b0, clr_halt = 1'b0, eng_stall_req = 1'b0, pkt_done = 1'b0;
  logic       tok_valid = 1'b0, tok_in = 1'b0;
  logic [1:0] hs_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ep_hs_ctl u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_reset(bus_reset),
    .clr_halt(clr_halt), .eng_stall_req(eng_stall_req), .pkt_done(pkt_done),
    .tok_valid(tok_valid), .tok_in(tok_in), .hs_code(hs_code)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wipe();
    clr_halt = 1'b1; pkt_done = 1'b1;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
    step();
    clr_halt = 1'b0; pkt_done = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  function automatic int exp_hs(input int s, input int tok);
    bit en, st, arm;
    en = s[0]; st = s[1]; arm = s[2];
    if (tok == 0 || !en) return 0;
    if (st) return 3;
    if (tok == 1) return arm ? 1 : 2;  // IN
    return arm ? 2 : 1;                // OUT
  endfunction

  initial begin
    repeat (3) step();
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 hs", hs_code, 0);
    rst = 1'b0;
    step();

    // R2 R3 read-back mask over all write values
    for (int v = 0; v < 256; v++) begin
      wipe();
      wr(8'(v));
      chk("R2 mask", reg_rdata, v & 7);
    end

    // R7 R8 R9 all flag states against every token kind
    for (int s = 0; s < 8; s++) begin
      wipe();
      wr(8'(s));
      chk("R3 state", reg_rdata, s);
      for (int t = 0; t < 3; t++) begin
        tok_valid = (t != 0); tok_in = (t == 1);
        step();
        tok_valid = 1'b0; tok_in = 1'b0;
        if (s[0] == 0 || t == 0) chk("R7 hs", hs_code, exp_hs(s, t));
        else if (s[1])           chk("R8 hs", hs_code, exp_hs(s, t));
        else                     chk("R9 hs", hs_code, exp_hs(s, t));
        step();
        chk("R7 idle", hs_code, 0);
      end
    end

    // R4 writing 0 keeps halt; engine request sets it
    wipe(); wr(8'h02); wr(8'h01);
    chk("R4 write0", reg_rdata, 8'h03);
    wipe(); eng_stall_req = 1'b1; step(); eng_stall_req = 1'b0;
    chk("R4 engine", reg_rdata, 8'h02);

    // R5 clear beats set in same cycle
    wipe();
    reg_sel = 1; reg_wr = 1; reg_wdata = 8'h03; clr_halt = 1; step();
    reg_sel = 0; reg_wr = 0; clr_halt = 0;
    chk("R5 clr_vs_wr", reg_rdata, 8'h01);
    wr(8'h03);
    eng_stall_req = 1; bus_reset = 1; step(); eng_stall_req = 0; bus_reset = 0;
    chk("R5 busrst_vs_eng", reg_rdata, 8'h01);

    // R6 arm behaviour
    wipe(); wr(8'h05); wr(8'h01);
    chk("R6 write0", reg_rdata, 8'h05);
    reg_sel = 1; reg_wr = 1; reg_wdata = 8'h05; pkt_done = 1; step();
    reg_sel = 0; reg_wr = 0; pkt_done = 0;
    chk("R6 done_vs_wr", reg_rdata, 8'h01);
    wr(8'h03);
    pkt_done = 1; step(); pkt_done = 0;
    chk("R6 idle_done", reg_rdata, 8'h03);

    // R10 strobe without select
    wipe(); wr(8'h05);
    reg_wr = 1; reg_wdata = 8'hFA; step(); reg_wr = 0;
    chk("R10 nosel", reg_rdata, 8'h05);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule